// File: doc/BRIEF.md
# Two-Level Edge-Triggered Interrupt Combiner

The block gathers interrupt causes raised by an embedded engine and presents them to a host on a single interrupt line. It has two stages.

The first stage, the cause stage, holds eight cause-status bits and eight enable bits. The engine sets status bits with single-cycle pulses, and the host clears them by writing ones. This stage produces an event only when, for some bit, status and enable go from "not both set" to "both set". A condition that simply stays true never produces a second event.

The second stage, the combiner stage, keeps one sticky pending bit for each of its two sources:
- source 0 is the engine-to-host mailbox pulse;
- source 1 is the cause-stage event.

Each source also has an enable bit and a mask bit. The host line is high while any source is pending, enabled and not masked.

A small readiness handshake shares the register port. The host declares itself ready, and the engine declares itself ready with a pulse. The system counts as ready only when both parties are ready. A clear command drops both ready flags. The handshake is a four-state machine:

| State | Meaning |
| --- | --- |
| `RDY_NONE` | neither party is ready |
| `RDY_HOST` | only the host is ready |
| `RDY_ENGINE` | only the engine is ready |
| `RDY_LINKED` | both parties are ready |

Its transitions:
- A host-set moves `RDY_NONE` to `RDY_HOST`.
- An engine-set moves `RDY_NONE` to `RDY_ENGINE`.
- Both sets together move `RDY_NONE` to `RDY_LINKED`.
- An engine-set moves `RDY_HOST` to `RDY_LINKED`.
- A host-set moves `RDY_ENGINE` to `RDY_LINKED`.
- `RDY_LINKED` holds until a clear.
- A clear moves every state to `RDY_NONE`.

Every entry into `RDY_LINKED` raises cause bit 0.

Register access uses a write strobe, an address and write data. Read data is returned combinationally from the address.

Top module: `irqagg_host`

## Requirements
- R1: After reset, every register reads 0, `host_irq` is 0 and `sys_ready` is 0.
- R2: A pulse on `cause_pulse[i]` sets cause-status bit i at the next clock. Writing a 1 to bit i at offset 0x00 clears that bit. When a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R3: Only cause bits 0 to 2 are implemented. Bits 3 to 7 of the cause status (0x00) and of the cause enable (0x04) always read 0, and pulses on them have no effect.
- R4: Combiner status bit 1 (offset 0x20) becomes 1 two clocks after any cause bit goes from "status and enable not both 1" to "both 1". This includes writing an enable while the status is already 1. A condition that stays true does not set the bit again after the host clears it. An edge that coincides with a host clear of bit 1 leaves the bit set.
- R5: A pulse on `mbox_pulse` sets combiner status bit 0 at the next clock. Writing 1 to bit 0 at 0x20 clears it, except in a cycle with a new pulse.
- R6: Writes to offset 0x24 load the combiner enable bits 1:0, and writes to 0x28 load the mask bits 1:0. Offset 0x2C reads status AND enable AND NOT mask for each source. `host_irq` is the OR of those bits.
- R7: At offset 0x08, writing bit 0 marks the host ready and `eng_ready_pulse` marks the engine ready. The register reads back {engine, host} in bits 1:0. `sys_ready` is 1 only when both are ready. Writing bit 2 clears both flags, and it wins over a host set in the same write.
- R8: Each entry into the linked state (both parties ready) sets cause-status bit 0 in the same clock.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| cause_pulse | input | NUM_CAUSE | Engine-side cause set pulses |
| mbox_pulse | input | 1 | Engine-to-host mailbox event pulse |
| eng_ready_pulse | input | 1 | Engine declares itself ready |
| sys_ready | output | 1 | Both parties ready |
| host_irq | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is a cause-stage edge that lands in the same cycle as a host clear of the combiner's bridge-pending bit. The edge detector lags the status register by one cycle, so the stimulus first pulses a cause bit whose enable is already on. In the very next cycle it writes the clear to offset 0x20, and the check then confirms that the pending bit survived.

A second hard case is the edge caused by enabling a bit whose status is already set. The bench reaches it by letting the status settle while the bit is disabled and only then writing the enable.

A behavioural model in the bench follows every register and the interrupt line on every cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int REG_ADDR_W  = 6;
    localparam int SRC_COUNT   = 2;
    localparam int SRC_MAILBOX = 0;
    localparam int SRC_BRIDGE  = 1;

    // Register offsets (bytes)
    localparam logic [REG_ADDR_W-1:0] OFS_CAUSE_STS  = 6'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_CAUSE_EN   = 6'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_READY      = 6'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_TOP_STS    = 6'h20;
    localparam logic [REG_ADDR_W-1:0] OFS_TOP_EN     = 6'h24;
    localparam logic [REG_ADDR_W-1:0] OFS_TOP_MASK   = 6'h28;
    localparam logic [REG_ADDR_W-1:0] OFS_TOP_ACTIVE = 6'h2C;

    // Bit positions within the readiness register
    localparam int RDY_BIT_HOST  = 0;
    localparam int RDY_BIT_ENG   = 1;
    localparam int RDY_BIT_CLEAR = 2;

    typedef enum logic [1:0] {
        RDY_NONE,
        RDY_HOST,
        RDY_ENGINE,
        RDY_LINKED
    } rdy_state_t;

endpackage

// File: rtl/irqagg_ready_fsm.sv
module irqagg_ready_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_set,
    input  logic eng_set,
    input  logic rdy_clr,
    output logic host_rdy,
    output logic eng_rdy,
    output logic sys_ready,
    output logic link_evt
);

    rdy_state_t state_q;
    rdy_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RDY_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a clear overrides any set in the same cycle
    always_comb begin
        state_d = state_q;
        if (rdy_clr) begin
            state_d = RDY_NONE;
        end else begin
            unique case (state_q)
                RDY_NONE: begin
                    if (host_set && eng_set) begin
                        state_d = RDY_LINKED;
                    end else if (host_set) begin
                        state_d = RDY_HOST;
                    end else if (eng_set) begin
                        state_d = RDY_ENGINE;
                    end
                end
                RDY_HOST: begin
                    if (eng_set) begin
                        state_d = RDY_LINKED;
                    end
                end
                RDY_ENGINE: begin
                    if (host_set) begin
                        state_d = RDY_LINKED;
                    end
                end
                RDY_LINKED: begin
                    state_d = RDY_LINKED;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        host_rdy  = (state_q == RDY_HOST)   || (state_q == RDY_LINKED);
        eng_rdy   = (state_q == RDY_ENGINE) || (state_q == RDY_LINKED);
        sys_ready = (state_q == RDY_LINKED);
        link_evt  = (state_d == RDY_LINKED) && (state_q != RDY_LINKED);
    end

    // R7: a clear command leaves no party ready on the next cycle
    a_r7_clear_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_clr |=> (!sys_ready && !host_rdy && !eng_rdy));

    // R7: system readiness only ever appears together with both flags
    a_r7_ready_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_ready) |-> ($past(host_set || host_rdy) && $past(eng_set || eng_rdy)));

endmodule

// File: rtl/irqagg_cause_level.sv
module irqagg_cause_level #(
    parameter int                   NUM_CAUSE = 8,
    parameter logic [NUM_CAUSE-1:0] IMPL_MASK = 8'h07
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] set_vec,
    input  logic [NUM_CAUSE-1:0] clr_vec,
    input  logic                 en_wr,
    input  logic [NUM_CAUSE-1:0] en_wdata,
    output logic [NUM_CAUSE-1:0] sts,
    output logic [NUM_CAUSE-1:0] en,
    output logic                 bridge_evt
);

    logic [NUM_CAUSE-1:0] sts_q;
    logic [NUM_CAUSE-1:0] en_q;
    logic [NUM_CAUSE-1:0] cond_q;
    logic [NUM_CAUSE-1:0] cond;
    logic [NUM_CAUSE-1:0] rise_vec;

    // Status and enable registers, plus the previous combined condition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= '0;
            en_q   <= '0;
            cond_q <= '0;
        end else begin
            sts_q  <= ((sts_q & ~clr_vec) | set_vec) & IMPL_MASK;
            if (en_wr) begin
                en_q <= en_wdata & IMPL_MASK;
            end
            cond_q <= cond;
        end
    end

    // Rising-edge detection on status AND enable, one bit per cause
    assign cond       = sts_q & en_q;
    assign rise_vec   = cond & ~cond_q;
    assign bridge_evt = |rise_vec;
    assign sts        = sts_q;
    assign en         = en_q;

    // R2: an implemented set pulse is never lost, even against a clear
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & IMPL_MASK)) |=> ((sts & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

    // R4: an event needs a cause with both status and enable set
    a_r4_edge_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_evt |-> (|(sts & en)));

    // R3: unimplemented cause bits stay quiet
    a_r3_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts | en) & ~IMPL_MASK) == '0);

endmodule

// File: rtl/irqagg_top_level.sv
module irqagg_top_level
    import irqagg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_evt,
    input  logic [SRC_COUNT-1:0] clr_vec,
    input  logic                 en_wr,
    input  logic [SRC_COUNT-1:0] en_wdata,
    input  logic                 mask_wr,
    input  logic [SRC_COUNT-1:0] mask_wdata,
    output logic [SRC_COUNT-1:0] sts,
    output logic [SRC_COUNT-1:0] en,
    output logic [SRC_COUNT-1:0] mask,
    output logic [SRC_COUNT-1:0] active,
    output logic                 host_irq
);

    logic [SRC_COUNT-1:0] sts_q;
    logic [SRC_COUNT-1:0] en_q;
    logic [SRC_COUNT-1:0] mask_q;

    // Sticky pending bits (set wins over clear), enable and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= '0;
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | src_evt;
            if (en_wr) begin
                en_q <= en_wdata;
            end
            if (mask_wr) begin
                mask_q <= mask_wdata;
            end
        end
    end

    assign active   = sts_q & en_q & ~mask_q;
    assign host_irq = |active;
    assign sts      = sts_q;
    assign en       = en_q;
    assign mask     = mask_q;

    // R5: a mailbox pulse is pending on the next cycle
    a_r5_mailbox_latched: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[SRC_MAILBOX] |=> sts[SRC_MAILBOX]);

    // R4: a cause-stage event is pending on the next cycle
    a_r4_bridge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[SRC_BRIDGE] |=> sts[SRC_BRIDGE]);

    // R6: fully masked sources never drive the host line
    a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !host_irq);

endmodule

// File: rtl/irqagg_host.sv
module irqagg_host
    import irqagg_pkg::*;
#(
    parameter int                   DATA_W     = 32,
    parameter int                   NUM_CAUSE  = 8,
    parameter logic [NUM_CAUSE-1:0] CAUSE_IMPL = 8'h07
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_CAUSE-1:0]  cause_pulse,
    input  logic                  mbox_pulse,
    input  logic                  eng_ready_pulse,
    output logic                  sys_ready,
    output logic                  host_irq
);

    logic                 wr_cause_sts;
    logic                 wr_cause_en;
    logic                 wr_ready;
    logic                 wr_top_sts;
    logic                 wr_top_en;
    logic                 wr_top_mask;

    logic                 host_rdy;
    logic                 eng_rdy;
    logic                 link_evt;

    logic [NUM_CAUSE-1:0] cause_set;
    logic [NUM_CAUSE-1:0] cause_clr;
    logic [NUM_CAUSE-1:0] cause_sts;
    logic [NUM_CAUSE-1:0] cause_en;
    logic                 bridge_evt;

    logic [SRC_COUNT-1:0] top_evt;
    logic [SRC_COUNT-1:0] top_clr;
    logic [SRC_COUNT-1:0] top_sts;
    logic [SRC_COUNT-1:0] top_en;
    logic [SRC_COUNT-1:0] top_mask;
    logic [SRC_COUNT-1:0] top_active;

    logic                 unused_wdata_hi;

    // Write decode
    assign wr_cause_sts = reg_wr && (reg_addr == OFS_CAUSE_STS);
    assign wr_cause_en  = reg_wr && (reg_addr == OFS_CAUSE_EN);
    assign wr_ready     = reg_wr && (reg_addr == OFS_READY);
    assign wr_top_sts   = reg_wr && (reg_addr == OFS_TOP_STS);
    assign wr_top_en    = reg_wr && (reg_addr == OFS_TOP_EN);
    assign wr_top_mask  = reg_wr && (reg_addr == OFS_TOP_MASK);

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CAUSE];

    irqagg_ready_fsm u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_set  (wr_ready && reg_wdata[RDY_BIT_HOST]),
        .eng_set   (eng_ready_pulse),
        .rdy_clr   (wr_ready && reg_wdata[RDY_BIT_CLEAR]),
        .host_rdy  (host_rdy),
        .eng_rdy   (eng_rdy),
        .sys_ready (sys_ready),
        .link_evt  (link_evt)
    );

    assign cause_set = cause_pulse | {{(NUM_CAUSE-1){1'b0}}, link_evt};
    assign cause_clr = wr_cause_sts ? reg_wdata[NUM_CAUSE-1:0] : '0;

    irqagg_cause_level #(
        .NUM_CAUSE (NUM_CAUSE),
        .IMPL_MASK (CAUSE_IMPL)
    ) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (cause_set),
        .clr_vec    (cause_clr),
        .en_wr      (wr_cause_en),
        .en_wdata   (reg_wdata[NUM_CAUSE-1:0]),
        .sts        (cause_sts),
        .en         (cause_en),
        .bridge_evt (bridge_evt)
    );

    always_comb begin
        top_evt              = '0;
        top_evt[SRC_MAILBOX] = mbox_pulse;
        top_evt[SRC_BRIDGE]  = bridge_evt;
    end

    assign top_clr = wr_top_sts ? reg_wdata[SRC_COUNT-1:0] : '0;

    irqagg_top_level u_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (top_evt),
        .clr_vec    (top_clr),
        .en_wr      (wr_top_en),
        .en_wdata   (reg_wdata[SRC_COUNT-1:0]),
        .mask_wr    (wr_top_mask),
        .mask_wdata (reg_wdata[SRC_COUNT-1:0]),
        .sts        (top_sts),
        .en         (top_en),
        .mask       (top_mask),
        .active     (top_active),
        .host_irq   (host_irq)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CAUSE_STS:  reg_rdata[NUM_CAUSE-1:0]  = cause_sts;
            OFS_CAUSE_EN:   reg_rdata[NUM_CAUSE-1:0]  = cause_en;
            OFS_READY: begin
                reg_rdata[RDY_BIT_HOST] = host_rdy;
                reg_rdata[RDY_BIT_ENG]  = eng_rdy;
            end
            OFS_TOP_STS:    reg_rdata[SRC_COUNT-1:0]  = top_sts;
            OFS_TOP_EN:     reg_rdata[SRC_COUNT-1:0]  = top_en;
            OFS_TOP_MASK:   reg_rdata[SRC_COUNT-1:0]  = top_mask;
            OFS_TOP_ACTIVE: reg_rdata[SRC_COUNT-1:0]  = top_active;
            default:        reg_rdata = '0;
        endcase
    end

    // R8: entering the linked state raises cause bit 0
    a_r8_link_sets_cause0: assert property (@(posedge clk) disable iff (!rst_n)
        (link_evt && CAUSE_IMPL[0]) |=> cause_sts[0]);

    // R7: the readiness output agrees with the flags read back
    a_r7_ready_flags: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ready |-> (host_rdy && eng_rdy));

endmodule

// File: tb/irqagg_host_tb.sv
`timescale 1ns/1ps
module irqagg_host_tb_top;

    localparam logic [7:0] IMPL = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  cause_pulse = '0;
    logic        mbox_pulse = 1'b0;
    logic        eng_ready_pulse = 1'b0;
    logic        sys_ready;
    logic        host_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit run_cmp = 1'b0;

    always #4 clk = ~clk;

    irqagg_host dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .cause_pulse     (cause_pulse),
        .mbox_pulse      (mbox_pulse),
        .eng_ready_pulse (eng_ready_pulse),
        .sys_ready       (sys_ready),
        .host_irq        (host_irq)
    );

    // Behavioural reference model
    logic [7:0] m_csts, m_cen, m_cq, t_cclr, t_cond;
    logic [1:0] m_usts, m_uen, m_umask, t_uclr;
    logic       m_h, m_e, t_h, t_e, t_rw, t_rclr, t_link, t_edge;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_csts = '0; m_cen = '0; m_cq = '0;
            m_usts = '0; m_uen = '0; m_umask = '0;
            m_h = 1'b0; m_e = 1'b0;
        end else begin
            t_cclr = (reg_wr && reg_addr == 6'h00) ? reg_wdata[7:0] : 8'h00;
            t_rw   = reg_wr && (reg_addr == 6'h08);
            t_rclr = t_rw && reg_wdata[2];
            t_h    = t_rclr ? 1'b0 : (m_h | (t_rw & reg_wdata[0]));
            t_e    = t_rclr ? 1'b0 : (m_e | eng_ready_pulse);
            t_link = t_h & t_e & ~(m_h & m_e);
            t_cond = m_csts & m_cen;
            t_edge = |(t_cond & ~m_cq);
            m_cq   = t_cond;
            m_csts = ((m_csts & ~t_cclr) | cause_pulse | {7'b0, t_link}) & IMPL;
            if (reg_wr && reg_addr == 6'h04) m_cen = reg_wdata[7:0] & IMPL;
            t_uclr = (reg_wr && reg_addr == 6'h20) ? reg_wdata[1:0] : 2'b00;
            m_usts = (m_usts & ~t_uclr) | {t_edge, mbox_pulse};
            if (reg_wr && reg_addr == 6'h24) m_uen = reg_wdata[1:0];
            if (reg_wr && reg_addr == 6'h28) m_umask = reg_wdata[1:0];
            m_h = t_h;
            m_e = t_e;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00:   return {24'h0, m_csts};
            6'h04:   return {24'h0, m_cen};
            6'h08:   return {30'h0, m_e, m_h};
            6'h20:   return {30'h0, m_usts};
            6'h24:   return {30'h0, m_uen};
            6'h28:   return {30'h0, m_umask};
            6'h2C:   return {30'h0, m_usts & m_uen & ~m_umask};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00:   return "R2 cause status";
            6'h04:   return "R3 cause enable";
            6'h08:   return "R7 readiness";
            6'h20:   return "R5 combiner status";
            default: return "R6 combiner regs";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
            chk("R6 host_irq per-cycle", 32'(host_irq), 32'(|(m_usts & m_uen & ~m_umask)));
            chk("R7 sys_ready per-cycle", 32'(sys_ready), 32'(m_h & m_e));
        end
    end

    task automatic cyc(input logic wr, input logic [5:0] a, input logic [31:0] d,
                       input logic [7:0] cp, input logic mb, input logic ep);
        @(negedge clk);
        #1;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        cause_pulse = cp; mbox_pulse = mb; eng_ready_pulse = ep;
    endtask

    task automatic idle();
        cyc(1'b0, 6'h00, 32'h0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, a, 32'h0, 8'h00, 1'b0, 1'b0);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        run_cmp = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;

        // R1: reset state
        rd_chk(6'h00, 32'h0, "R1 cause status");
        rd_chk(6'h04, 32'h0, "R1 cause enable");
        rd_chk(6'h08, 32'h0, "R1 readiness");
        rd_chk(6'h20, 32'h0, "R1 combiner status");
        rd_chk(6'h2C, 32'h0, "R1 active");
        chk("R1 host_irq", 32'(host_irq), 32'h0);
        chk("R1 sys_ready", 32'(sys_ready), 32'h0);

        // Status while disabled raises nothing (R4)
        wr(6'h24, 32'h3);
        cyc(1'b0, 6'h00, 32'h0, 8'h02, 1'b0, 1'b0);
        idle(); idle();
        rd_chk(6'h00, 32'h2, "R2 cause set by pulse");
        rd_chk(6'h20, 32'h0, "R4 no edge while disabled");

        // Enable written over existing status is an edge (R4)
        wr(6'h04, 32'h2);
        idle();
        rd_chk(6'h20, 32'h2, "R4 enable-after-status edge");
        rd_chk(6'h2C, 32'h2, "R6 active readback");
        chk("R6 host_irq raised", 32'(host_irq), 32'h1);

        // Held level does not re-raise after clear (R4)
        wr(6'h20, 32'h2);
        idle(); idle(); idle();
        rd_chk(6'h20, 32'h0, "R4 held level no re-raise");
        chk("R6 host_irq dropped", 32'(host_irq), 32'h0);

        // Mailbox source and masking (R5, R6)
        cyc(1'b0, 6'h00, 32'h0, 8'h00, 1'b1, 1'b0);
        rd_chk(6'h20, 32'h1, "R5 mailbox pending");
        chk("R5 host_irq from mailbox", 32'(host_irq), 32'h1);
        wr(6'h28, 32'h1);
        rd_chk(6'h2C, 32'h0, "R6 masked active");
        chk("R6 host_irq masked", 32'(host_irq), 32'h0);
        rd_chk(6'h20, 32'h1, "R6 mask keeps status");
        wr(6'h28, 32'h0);
        cyc(1'b1, 6'h20, 32'h1, 8'h00, 1'b1, 1'b0);
        rd_chk(6'h20, 32'h1, "R5 set wins over clear");
        wr(6'h20, 32'h1);
        rd_chk(6'h20, 32'h0, "R5 clear");
        chk("R6 host_irq idle", 32'(host_irq), 32'h0);

        // Cause set and clear in one cycle (R2)
        cyc(1'b1, 6'h00, 32'h2, 8'h02, 1'b0, 1'b0);
        rd_chk(6'h00, 32'h2, "R2 set wins over clear");
        wr(6'h00, 32'h2);
        rd_chk(6'h00, 32'h0, "R2 clear by write-one");

        // Unimplemented bits (R3)
        wr(6'h04, 32'hFF);
        rd_chk(6'h04, 32'h7, "R3 enable upper bits");
        cyc(1'b0, 6'h00, 32'h0, 8'hF8, 1'b0, 1'b0);
        idle();
        rd_chk(6'h00, 32'h0, "R3 status upper bits");
        rd_chk(6'h20, 32'h0, "R3 no edge from upper bits");

        // Readiness handshake (R7, R8)
        wr(6'h08, 32'h1);
        rd_chk(6'h08, 32'h1, "R7 host ready");
        chk("R7 not yet ready", 32'(sys_ready), 32'h0);
        cyc(1'b0, 6'h00, 32'h0, 8'h00, 1'b0, 1'b1);
        rd_chk(6'h08, 32'h3, "R7 both ready");
        chk("R7 sys_ready", 32'(sys_ready), 32'h1);
        rd_chk(6'h00, 32'h1, "R8 link sets cause 0");
        rd_chk(6'h20, 32'h2, "R8 link edge pending");
        chk("R8 host_irq", 32'(host_irq), 32'h1);
        wr(6'h08, 32'h5);
        rd_chk(6'h08, 32'h0, "R7 clear wins");
        chk("R7 sys_ready cleared", 32'(sys_ready), 32'h0);
        cyc(1'b0, 6'h00, 32'h0, 8'h00, 1'b0, 1'b1);
        rd_chk(6'h08, 32'h2, "R7 engine only");
        wr(6'h08, 32'h4);
        rd_chk(6'h08, 32'h0, "R7 cleared again");

        // Edge coincides with combiner clear (R4)
        cyc(1'b0, 6'h00, 32'h0, 8'h04, 1'b0, 1'b0);
        wr(6'h20, 32'h2);
        rd_chk(6'h20, 32'h2, "R4 edge wins over clear");
        wr(6'h20, 32'h2);
        rd_chk(6'h20, 32'h0, "R4 cleared after");

        idle(); idle();
        finish_run();
    end

endmodule